// File: doc/BRIEF.md
# Paged Program Counter Unit

This block keeps the 13-bit instruction address of a small processor core, covering a flat space of 8192 words. In normal operation it advances by one word per enabled cycle. Jump and subroutine-call instructions carry only an 11-bit target, so such a branch can reach any word inside a 2048-word page. The two page bits that complete the address are taken from bits 4:3 of a separate page-select register, which software writes through its own port before branching.

A return from a subroutine or from an interrupt handler does not use the page register. The full 13-bit address comes back from an external return stack and is loaded as it is. During a call, the unit presents the address of the following instruction together with a push strobe, so that the stack can store it. The stack storage and the instruction fetch path are outside this block.

Top module: `paged_pc_unit`

## Requirements
- R1: While `rst_n` is low, the program counter and the whole page register are cleared to zero. A branch taken just after reset therefore lands in page 0.
- R2: When only `step_en` is requested, the counter advances by one on the next clock edge, and 0x1FFF wraps to 0x0000.
- R3: With no request active, the counter keeps its value.
- R4: A branch (`br_valid` with no return) loads {page register bits 4:3, `br_target`}. Page register bits 7:5 and 2:0 have no effect on the address.
- R5: A return (`ret_valid`) loads all 13 bits of `ret_addr` exactly as given, whatever the page register holds.
- R6: When requests coincide, the order of precedence is reset, then return, then branch, then step.
- R7: `push_valid` is high in exactly those cycles where `br_valid` and `br_is_call` are high and `ret_valid` is low. While it is high, `push_addr` equals the current PC plus one, modulo 8192. A jump (`br_is_call` low) never raises `push_valid`.
- R8: A page register write takes effect on the next clock edge. A branch in the same cycle as the write still uses the previous value. Branches, calls and returns never change the page register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Advance to the next sequential word |
| br_valid | input | 1 | Take a branch to the paged target |
| br_is_call | input | 1 | Qualifies a branch as a call (request a push) |
| br_target | input | 11 | Address of the target within its page |
| page_we | input | 1 | Write strobe for the page register |
| page_wdata | input | 8 | New page register value (bits 4:3 select the page) |
| ret_valid | input | 1 | Restore the PC from the return stack |
| ret_addr | input | 13 | Full return address popped from the stack |
| pc | output | 13 | Current program counter |
| push_valid | output | 1 | Push request during a call |
| push_addr | output | 13 | Return address to push (PC + 1) |

## Verification
Assertions check the following on every cycle: the outcome of each kind of request (hold, step with wrap, paged branch, full return), that at most one source is selected, that the push strobe matches the call qualifier, and that the page register holds its value when it is not written. The cases that need a sequence of cycles are shown only by the bench scenarios. These are a page written in the same cycle as a branch, which must use the old page. They also include a return whose address lies outside the current page, and the carry from 0x1FFF to 0x0000. Random mixes of all the strobes are compared against a model of the precedence order.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  // Which source loads the program counter in a given cycle
  typedef enum logic [1:0] {
    SEL_HOLD   = 2'd0,
    SEL_STEP   = 2'd1,
    SEL_BRANCH = 2'd2,
    SEL_RETURN = 2'd3
  } pc_sel_e;
endpackage

// File: rtl/pcu_page_latch.sv
module pcu_page_latch #(
  parameter int LATCH_W  = 8,
  parameter int PAGE_W   = 2,
  parameter int PAGE_LSB = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [LATCH_W-1:0] wdata,
  output logic [PAGE_W-1:0]  page
);
  localparam int PAGE_MSB = PAGE_LSB + PAGE_W - 1;

  logic [LATCH_W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata;
  end

  assign page = q[PAGE_MSB:PAGE_LSB];

  // The register changes only through its own write port
  p_latch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
  p_latch_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> q == $past(wdata));
endmodule

// File: rtl/pcu_next_sel.sv
module pcu_next_sel
  import pcu_pkg::*;
#(
  parameter int PC_W = 13,
  parameter int BR_W = 11
) (
  input  logic [PC_W-1:0]      pc,
  input  logic [PC_W-BR_W-1:0] page,
  input  logic                 step_en,
  input  logic                 br_valid,
  input  logic [BR_W-1:0]      br_target,
  input  logic                 ret_valid,
  input  logic [PC_W-1:0]      ret_addr,
  output pc_sel_e              sel,
  output logic [PC_W-1:0]      pc_next,
  output logic [PC_W-1:0]      pc_plus1
);
  localparam int PAGE_W = PC_W - BR_W;

  function automatic logic [PC_W-1:0] f_incr(input logic [PC_W-1:0] a);
    return a + PC_W'(1);
  endfunction

  function automatic logic [PC_W-1:0] f_join(input logic [PAGE_W-1:0] pg,
                                              input logic [BR_W-1:0]  off);
    return {pg, off};
  endfunction

  always_comb begin
    if (ret_valid)     sel = SEL_RETURN;
    else if (br_valid) sel = SEL_BRANCH;
    else if (step_en)  sel = SEL_STEP;
    else               sel = SEL_HOLD;
  end

  assign pc_plus1 = f_incr(pc);

  always_comb begin
    unique case (sel)
      SEL_RETURN: pc_next = ret_addr;
      SEL_BRANCH: pc_next = f_join(page, br_target);
      SEL_STEP:   pc_next = pc_plus1;
      default:    pc_next = pc;
    endcase
  end
endmodule

// File: rtl/paged_pc_unit.sv
module paged_pc_unit
  import pcu_pkg::*;
#(
  parameter int PC_W     = 13,
  parameter int BR_W     = 11,
  parameter int LATCH_W  = 8,
  parameter int PAGE_LSB = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_en,
  input  logic               br_valid,
  input  logic               br_is_call,
  input  logic [BR_W-1:0]    br_target,
  input  logic               page_we,
  input  logic [LATCH_W-1:0] page_wdata,
  input  logic               ret_valid,
  input  logic [PC_W-1:0]    ret_addr,
  output logic [PC_W-1:0]    pc,
  output logic               push_valid,
  output logic [PC_W-1:0]    push_addr
);
  localparam int PAGE_W = PC_W - BR_W;

  logic [PAGE_W-1:0] page;
  pc_sel_e           sel;
  logic [PC_W-1:0]   pc_next;
  logic [PC_W-1:0]   pc_plus1;

  // Named events for the assertions
  logic ev_ret, ev_br, ev_step, ev_hold;
  assign ev_ret  = (sel == SEL_RETURN);
  assign ev_br   = (sel == SEL_BRANCH);
  assign ev_step = (sel == SEL_STEP);
  assign ev_hold = (sel == SEL_HOLD);

  pcu_page_latch #(.LATCH_W(LATCH_W), .PAGE_W(PAGE_W), .PAGE_LSB(PAGE_LSB)) u_latch (
    .clk(clk), .rst_n(rst_n), .we(page_we), .wdata(page_wdata), .page(page)
  );

  pcu_next_sel #(.PC_W(PC_W), .BR_W(BR_W)) u_sel (
    .pc(pc), .page(page), .step_en(step_en), .br_valid(br_valid),
    .br_target(br_target), .ret_valid(ret_valid), .ret_addr(ret_addr),
    .sel(sel), .pc_next(pc_next), .pc_plus1(pc_plus1)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_next;
  end

  assign push_valid = ev_br & br_is_call;
  assign push_addr  = pc_plus1;

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> pc == '0);
  p_step_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step |=> pc == (($past(pc) == {PC_W{1'b1}}) ? '0 : $past(pc) + PC_W'(1)));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !br_valid && !ret_valid) |=> $stable(pc));
  p_branch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && !ret_valid) |=> pc == {$past(page), $past(br_target)});
  p_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> pc == $past(ret_addr));
  p_one_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_ret, ev_br, ev_step}) && (ev_hold == !(step_en || br_valid || ret_valid)));
  p_push_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid == (br_valid && br_is_call && !ret_valid));
endmodule

// File: tb/paged_pc_unit_test.sv
`timescale 1ns/1ps
module paged_pc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        step_en, br_valid, br_is_call, page_we, ret_valid;
  logic [10:0] br_target;
  logic [7:0]  page_wdata;
  logic [12:0] ret_addr;
  logic [12:0] pc, push_addr;
  logic        push_valid;

  int checks = 0;
  int fails  = 0;
  logic [12:0] m_pc;
  logic [7:0]  m_lat;

  always #2.5 clk = ~clk;

  paged_pc_unit uut (
    .clk(clk), .rst_n(rst_n), .step_en(step_en), .br_valid(br_valid),
    .br_is_call(br_is_call), .br_target(br_target), .page_we(page_we),
    .page_wdata(page_wdata), .ret_valid(ret_valid), .ret_addr(ret_addr),
    .pc(pc), .push_valid(push_valid), .push_addr(push_addr)
  );

  // Model of the precedence order, written independently
  function automatic logic [12:0] exp_pc(input logic [12:0] cur, input logic [7:0] lat,
      input logic st, input logic br, input logic [10:0] tg, input logic rt, input logic [12:0] ra);
    logic [13:0] w;
    if (rt) return ra;
    if (br) return {lat[4], lat[3], tg};
    if (st) begin w = {1'b0, cur} + 14'd1; return w[12:0]; end
    return cur;
  endfunction

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    step_en = 0; br_valid = 0; br_is_call = 0; page_we = 0; ret_valid = 0;
    br_target = '0; page_wdata = '0; ret_addr = '0;
  endtask

  // Inputs are set at the negedge; comb outputs checked, then state after the posedge
  task automatic cycle(input string req);
    logic pv_e;
    logic [13:0] w;
    #0.5;
    pv_e = br_valid && br_is_call && !ret_valid;
    check({req, " R7 push_valid"}, {12'd0, push_valid}, {12'd0, pv_e});
    if (pv_e) begin
      w = {1'b0, m_pc} + 14'd1;
      check({req, " R7 push_addr"}, push_addr, w[12:0]);
    end
    @(posedge clk);
    m_pc = exp_pc(m_pc, m_lat, step_en, br_valid, br_target, ret_valid, ret_addr);
    if (page_we) m_lat = page_wdata;
    @(negedge clk);
    check(req, pc, m_pc);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    rst_n = 0;
    m_pc = '0; m_lat = '0;
    repeat (3) @(negedge clk);
    check("R1 reset pc", pc, 13'h0000);
    rst_n = 1;
    @(negedge clk);
    // R1: branch right after reset stays in page 0
    br_valid = 1; br_target = 11'h5A5; cycle("R1 page zero after reset");
    check("R1 branch target", pc, 13'h05A5);
    idle();
    // R3 hold
    cycle("R3 hold"); cycle("R3 hold again");
    // R4 page bits 4:3 only
    page_we = 1; page_wdata = 8'h18; cycle("R8 page write");
    idle(); br_valid = 1; br_target = 11'h7FF; cycle("R4 page 3 branch");
    check("R4 top word", pc, 13'h1FFF);
    // R2 wrap
    idle(); step_en = 1; cycle("R2 wrap");
    check("R2 wrapped to zero", pc, 13'h0000);
    idle(); page_we = 1; page_wdata = 8'hE7; cycle("R8 other bits");
    idle(); br_valid = 1; br_target = 11'h123; cycle("R4 ignored bits");
    check("R4 only 4:3 count", pc, 13'h0123);
    // R8 same-cycle write uses old page
    idle(); page_we = 1; page_wdata = 8'h10; br_valid = 1; br_target = 11'h004; cycle("R8 old page used");
    check("R8 old page value", pc, 13'h0004);
    idle(); br_valid = 1; br_is_call = 1; br_target = 11'h004; cycle("R8 new page call");
    check("R8 new page value", pc, 13'h1004);
    // R5 return ignores page
    idle(); ret_valid = 1; ret_addr = 13'h0ABC; cycle("R5 return");
    check("R5 full restore", pc, 13'h0ABC);
    idle(); br_valid = 1; br_target = 11'h001; cycle("R8 page kept after call/return");
    check("R8 page kept", pc, 13'h1001);
    // R6 all at once
    idle(); ret_valid = 1; ret_addr = 13'h0777; br_valid = 1; br_is_call = 1; step_en = 1; cycle("R6 return wins");
    check("R6 return wins", pc, 13'h0777);
    idle(); br_valid = 1; br_target = 11'h222; step_en = 1; cycle("R6 branch beats step");
    // R7 goto no push
    idle(); br_valid = 1; br_is_call = 0; br_target = 11'h010; cycle("R7 goto");
    // Random mix
    for (int i = 0; i < 2000; i++) begin
      step_en    = $urandom_range(0, 1);
      br_valid   = ($urandom_range(0, 3) == 0);
      br_is_call = $urandom_range(0, 1);
      br_target  = 11'($urandom);
      page_we    = ($urandom_range(0, 4) == 0);
      page_wdata = 8'($urandom);
      ret_valid  = ($urandom_range(0, 7) == 0);
      ret_addr   = 13'($urandom);
      cycle("R6 random mix");
    end
    // R1 reset mid-run
    idle(); rst_n = 0; #0.5; m_pc = '0; m_lat = '0;
    check("R1 async reset", pc, 13'h0000);
    @(negedge clk); rst_n = 1; @(negedge clk);
    br_valid = 1; br_target = 11'h00F; cycle("R1 latch cleared");
    check("R1 latch cleared", pc, 13'h000F);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule